// File: doc/BRIEF.md
# Addressed Serial Display-Frame Receiver

This block takes display and control data from a host controller over a three-wire serial link (enable, clock, data) and keeps a 136-bit segment image plus a small set of panel control fields. All three link inputs are brought into the system clock domain through synchronizer flops. Link clock edges are detected there, so the link clock can run at any rate well below the system clock.

A transfer starts with an 8-bit device address, shifted in while enable is low. Enable then goes high and 48 payload bits follow. The last two payload bits pick one of four latch banks. When enable falls, the payload is committed to that bank, but only if the address matched and exactly 48 payload bits were seen. Only bank 0 also carries the control fields: the output-port mode, the bias select, the segments-off flag and the power-save flag. A display-enable input blanks the image and port-mode outputs without stopping transfers.

Top module: `seg_frame_rx`

## Requirements
- R1: After reset, `disp_img`, `port_mode`, `bias_half`, `seg_off` and `pwr_save` are all zero.
- R2: While `ce_in` is low, each rising edge of `sck_in` shifts `sdi_in` into an address register, least significant bit first. The last 8 bits before `ce_in` rises must equal 0x46, sent as 0,1,1,0,0,0,1,0. Otherwise the transfer changes no output.
- R3: While `ce_in` is high, payload bits are sampled on rising edges of `sck_in`. The first bit is payload bit 0. A transfer with fewer or more than 48 payload bits changes no output.
- R4: A valid payload is committed only after `ce_in` falls. Until then the outputs keep their earlier values.
- R5: Payload bits 46 and 47 (the 47th and 48th bits sent) form the bank number, with bit 46 as its high bit. Bank 0 writes payload bits 0..35 to image bits 0..35. Bank 1 writes them to bits 36..71. Bank 2 writes them to bits 72..107. Bank 3 writes payload bits 0..27 to image bits 108..135.
- R6: A bank-0 transfer loads the control fields. `port_mode` = {bit39, bit40, bit41, bit42}, with bit 39 as the most significant bit. `bias_half` = bit 43, `seg_off` = bit 44 and `pwr_save` = bit 45. Transfers to banks 1 to 3 leave the control fields unchanged, whatever bits 36..45 hold.
- R7: A committed transfer leaves all image bits outside its own bank unchanged.
- R8: Transfers are received the same way whether `sck_in` idles low or high between bits and around enable edges.
- R9: While `disp_en` is low, `disp_img` and `port_mode` read zero, and `bias_half`, `seg_off` and `pwr_save` still show the stored values. Transfers are still accepted. When `disp_en` returns high, the data written meanwhile appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_in | input | 1 | Link enable: low for the address, high for the payload |
| sck_in | input | 1 | Link clock; data is sampled on its rising edge |
| sdi_in | input | 1 | Link serial data |
| disp_en | input | 1 | High shows the image; low blanks the image and port mode |
| disp_img | output | 136 | Stored segment image |
| port_mode | output | 4 | Output-port mode code from bank 0 |
| bias_half | output | 1 | Bias select flag |
| seg_off | output | 1 | Segments-off flag |
| pwr_save | output | 1 | Power-save flag |

## Verification
The assertions check, on every cycle:
- the payload register never moves while enable is low;
- the address register never moves while enable is high;
- the bit counter never passes its overflow mark;
- a commit lasts exactly one cycle;
- the image holds without a commit;
- the control fields hold on commits to banks 1 to 3.

Only the bench scenarios can show the rest:
- the value checks: address match, bit order, bank placement, and rejection of short, long or misaddressed frames;
- that nothing changes before enable falls;
- reception with the clock idling high;
- behaviour while blanked, since these depend on whole serial sequences and on a model of the expected image.

// File: rtl/segrx_pkg.sv
package segrx_pkg;

    // Width of the bank selector carried at the end of each payload.
    localparam int DIR_W     = 2;
    // Zero bits between the display slice and the control fields.
    localparam int PAD_BITS  = 3;
    // Number of raw control bits carried by a bank-0 payload.
    localparam int CTRL_BITS = 7;

    typedef struct packed {
        logic [3:0] port_mode;
        logic       bias_half;
        logic       seg_off;
        logic       pwr_save;
    } ctrl_t;

endpackage

// File: rtl/segrx_sync.sv
module segrx_sync #(
    parameter int CH     = 3,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] raw_i,
    output logic [CH-1:0] lvl_o
);

    typedef struct packed {
        logic [STAGES-1:0][CH-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.pipe[STAGES-1];

endmodule

// File: rtl/segrx_frame.sv
module segrx_frame
    import segrx_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  DEV_ADDR = 8'h46,
    parameter int          PAY_W    = 48,
    parameter int          SLICE_W  = 36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_lvl_i,
    input  logic                 sck_lvl_i,
    input  logic                 sdi_lvl_i,
    output logic                 commit_o,
    output logic [SLICE_W-1:0]   disp_o,
    output logic [CTRL_BITS-1:0] ctrl_raw_o,
    output logic [DIR_W-1:0]     dir_o
);

    localparam int CNT_W    = $clog2(PAY_W + 2);
    localparam int CTRL_LSB = SLICE_W + PAD_BITS;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAY_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(PAY_W + 1);

    typedef struct packed {
        logic              ce_prev;
        logic              sck_prev;
        logic [ADDR_W-1:0] addr_sr;
        logic              addr_ok;
        logic [CNT_W-1:0]  cnt;
        logic [PAY_W-1:0]  pay;
        logic              commit;
    } frame_st_t;

    frame_st_t st_d, st_q;

    logic ce_rise, ce_fall, sck_rise;

    always_comb begin
        ce_rise  =  ce_lvl_i  & ~st_q.ce_prev;
        ce_fall  = ~ce_lvl_i  &  st_q.ce_prev;
        sck_rise =  sck_lvl_i & ~st_q.sck_prev;

        st_d          = st_q;
        st_d.ce_prev  = ce_lvl_i;
        st_d.sck_prev = sck_lvl_i;
        st_d.commit   = 1'b0;

        if (ce_rise) begin
            st_d.addr_ok = (st_q.addr_sr == DEV_ADDR[ADDR_W-1:0]);
            st_d.cnt     = '0;
            st_d.pay     = '0;
        end else if (ce_lvl_i && sck_rise) begin
            if (st_q.cnt != CNT_OVER) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt < CNT_FULL) begin
                st_d.pay = {sdi_lvl_i, st_q.pay[PAY_W-1:1]};
            end
        end else if (!ce_lvl_i && sck_rise) begin
            st_d.addr_sr = {sdi_lvl_i, st_q.addr_sr[ADDR_W-1:1]};
        end

        if (ce_fall) begin
            st_d.commit = st_q.addr_ok && (st_q.cnt == CNT_FULL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit_o   = st_q.commit;
    assign disp_o     = st_q.pay[SLICE_W-1:0];
    assign ctrl_raw_o = st_q.pay[CTRL_LSB +: CTRL_BITS];
    assign dir_o      = {st_q.pay[PAY_W-2], st_q.pay[PAY_W-1]};

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_OVER);

    // R3
    pay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_lvl_i |=> $stable(st_q.pay));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_lvl_i |=> $stable(st_q.addr_sr));

    // R4
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.commit |=> !st_q.commit);

endmodule

// File: rtl/segrx_store.sv
module segrx_store
    import segrx_pkg::*;
#(
    parameter int SLICE_W = 36,
    parameter int IMG_W   = 136
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit_i,
    input  logic [SLICE_W-1:0]   disp_i,
    input  logic [CTRL_BITS-1:0] ctrl_raw_i,
    input  logic [DIR_W-1:0]     dir_i,
    output logic [IMG_W-1:0]     img_o,
    output ctrl_t                ctrl_o
);

    localparam int NBANK = 1 << DIR_W;

    typedef struct packed {
        logic [IMG_W-1:0] img;
        ctrl_t            ctrl;
    } store_st_t;

    store_st_t st_d, st_q;

    logic [NBANK-1:0] bank_hit;
    logic [IMG_W-1:0] spread;
    logic [IMG_W-1:0] wmask;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int LO   = b * SLICE_W;
        localparam int BW   = ((IMG_W - LO) < SLICE_W) ? (IMG_W - LO) : SLICE_W;
        assign bank_hit[b] = commit_i && (dir_i == DIR_W'(b));
        if (BW > 0) begin : g_fill
            assign spread[LO +: BW] = disp_i[BW-1:0];
            assign wmask[LO +: BW]  = {BW{bank_hit[b]}};
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.img = (st_q.img & ~wmask) | (spread & wmask);
        if (bank_hit[0]) begin
            st_d.ctrl.port_mode = {ctrl_raw_i[0], ctrl_raw_i[1], ctrl_raw_i[2], ctrl_raw_i[3]};
            st_d.ctrl.bias_half = ctrl_raw_i[4];
            st_d.ctrl.seg_off   = ctrl_raw_i[5];
            st_d.ctrl.pwr_save  = ctrl_raw_i[6];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign img_o  = st_q.img;
    assign ctrl_o = st_q.ctrl;

    // R7
    img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(st_q.img));

    // R6
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (dir_i != '0)) |=> $stable(st_q.ctrl));

endmodule

// File: rtl/seg_frame_rx.sv
module seg_frame_rx
    import segrx_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] DEV_ADDR    = 8'h46,
    parameter int         PAY_W       = 48,
    parameter int         SLICE_W     = 36,
    parameter int         IMG_W       = 136,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_in,
    input  logic             sck_in,
    input  logic             sdi_in,
    input  logic             disp_en,
    output logic [IMG_W-1:0] disp_img,
    output logic [3:0]       port_mode,
    output logic             bias_half,
    output logic             seg_off,
    output logic             pwr_save
);

    localparam int LINK_CH = 3;

    logic [LINK_CH-1:0]   link_lvl;
    logic                 commit;
    logic [SLICE_W-1:0]   disp_slice;
    logic [CTRL_BITS-1:0] ctrl_raw;
    logic [DIR_W-1:0]     dir;
    logic [IMG_W-1:0]     img;
    ctrl_t                ctrl;

    segrx_sync #(
        .CH     (LINK_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sdi_in, sck_in, ce_in}),
        .lvl_o (link_lvl)
    );

    segrx_frame #(
        .ADDR_W   (ADDR_W),
        .DEV_ADDR (DEV_ADDR),
        .PAY_W    (PAY_W),
        .SLICE_W  (SLICE_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_lvl_i   (link_lvl[0]),
        .sck_lvl_i  (link_lvl[1]),
        .sdi_lvl_i  (link_lvl[2]),
        .commit_o   (commit),
        .disp_o     (disp_slice),
        .ctrl_raw_o (ctrl_raw),
        .dir_o      (dir)
    );

    segrx_store #(
        .SLICE_W (SLICE_W),
        .IMG_W   (IMG_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .disp_i     (disp_slice),
        .ctrl_raw_i (ctrl_raw),
        .dir_i      (dir),
        .img_o      (img),
        .ctrl_o     (ctrl)
    );

    assign disp_img  = disp_en ? img : '0;
    assign port_mode = disp_en ? ctrl.port_mode : 4'b0000;
    assign bias_half = ctrl.bias_half;
    assign seg_off   = ctrl.seg_off;
    assign pwr_save  = ctrl.pwr_save;

endmodule

// File: tb/seg_frame_rx_test.sv
module seg_frame_rx_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ce_in, sck_in, sdi_in, disp_en;
    logic [135:0] disp_img;
    logic [3:0]   port_mode;
    logic         bias_half, seg_off, pwr_save;

    always #10 clk = ~clk;

    seg_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .sck_in(sck_in), .sdi_in(sdi_in),
        .disp_en(disp_en), .disp_img(disp_img), .port_mode(port_mode),
        .bias_half(bias_half), .seg_off(seg_off), .pwr_save(pwr_save)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [135:0] exp_img;
    logic [3:0]   exp_mode;
    logic         exp_bias, exp_off, exp_ps;

    localparam logic [7:0] GOOD_ADDR = 8'h46;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmp(input string req, input string what, input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        cmp(req, "disp_img",  disp_img, disp_en ? exp_img : 136'd0);
        cmp(req, "port_mode", 136'(port_mode), disp_en ? 136'(exp_mode) : 136'd0);
        cmp(req, "bias_half", 136'(bias_half), 136'(exp_bias));
        cmp(req, "seg_off",   136'(seg_off),   136'(exp_off));
        cmp(req, "pwr_save",  136'(pwr_save),  136'(exp_ps));
    endtask

    task automatic put_bit(input logic b);
        sck_in = 1'b0;
        sdi_in = b;
        tick(4);
        sck_in = 1'b1;
        tick(4);
    endtask

    task automatic addr_phase(input logic [7:0] a, input bit idle_hi);
        ce_in = 1'b0;
        for (int i = 0; i < 8; i++) put_bit(a[i]);
        sck_in = idle_hi;
        tick(4);
    endtask

    task automatic payload_phase(input logic [47:0] p, input int n, input bit idle_hi);
        ce_in = 1'b1;
        tick(4);
        for (int i = 0; i < n; i++) put_bit((i < 48) ? p[i] : 1'b1);
        sck_in = idle_hi;
        tick(4);
    endtask

    task automatic close_frame();
        ce_in = 1'b0;
        tick(12);
    endtask

    function automatic logic [47:0] make_frame(input logic [1:0] bank, input logic [35:0] data,
                                               input logic [6:0] ctrl);
        logic [47:0] p = '0;
        p[35:0] = (bank == 2'd3) ? {8'h00, data[27:0]} : data;
        if (bank == 2'd0) p[45:39] = ctrl;
        p[46] = bank[1];
        p[47] = bank[0];
        return p;
    endfunction

    task automatic model_commit(input logic [1:0] bank, input logic [35:0] data, input logic [6:0] ctrl);
        case (bank)
            2'd0: begin
                exp_img[35:0] = data;
                exp_mode = {ctrl[0], ctrl[1], ctrl[2], ctrl[3]};
                exp_bias = ctrl[4];
                exp_off  = ctrl[5];
                exp_ps   = ctrl[6];
            end
            2'd1: exp_img[71:36]   = data;
            2'd2: exp_img[107:72]  = data;
            default: exp_img[135:108] = data[27:0];
        endcase
    endtask

    task automatic send(input logic [7:0] a, input logic [1:0] bank, input logic [35:0] data,
                        input logic [6:0] ctrl, input int n, input bit idle_hi);
        addr_phase(a, idle_hi);
        payload_phase(make_frame(bank, data, ctrl), n, idle_hi);
        close_frame();
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_bank0();
        send(GOOD_ADDR, 2'd0, 36'h9_A5C3_1E0F, 7'b1010011, 48, 1'b0);
        model_commit(2'd0, 36'h9_A5C3_1E0F, 7'b1010011);
        check_all("R5 R6 bank0");
        send(GOOD_ADDR, 2'd0, 36'h3_0F0F_F00C, 7'b0101100, 48, 1'b0);
        model_commit(2'd0, 36'h3_0F0F_F00C, 7'b0101100);
        check_all("R6 ctrl reload");
    endtask

    task automatic t_banks();
        send(GOOD_ADDR, 2'd1, 36'h1_2345_6789, 7'd0, 48, 1'b0);
        model_commit(2'd1, 36'h1_2345_6789, 7'd0);
        check_all("R5 R7 bank1");
        send(GOOD_ADDR, 2'd2, 36'hE_DCBA_9876, 7'd0, 48, 1'b0);
        model_commit(2'd2, 36'hE_DCBA_9876, 7'd0);
        check_all("R5 R7 bank2");
        send(GOOD_ADDR, 2'd3, 36'hF_FFFF_FFFF, 7'd0, 48, 1'b0);
        model_commit(2'd3, 36'hF_FFFF_FFFF, 7'd0);
        check_all("R5 R7 bank3");
    endtask

    task automatic t_idle_high();
        send(GOOD_ADDR, 2'd2, 36'h5_5AA5_C33C, 7'd0, 48, 1'b1);
        model_commit(2'd2, 36'h5_5AA5_C33C, 7'd0);
        check_all("R8 idle high bank2");
        send(GOOD_ADDR, 2'd0, 36'h0_0000_0001, 7'b1111111, 48, 1'b1);
        model_commit(2'd0, 36'h0_0000_0001, 7'b1111111);
        check_all("R8 idle high bank0");
        sck_in = 1'b0;
        tick(8);
    endtask

    task automatic t_bad_addr();
        send(8'h47, 2'd1, 36'h0_0000_0000, 7'd0, 48, 1'b0);
        check_all("R2 wrong address");
        send(8'h62, 2'd0, 36'hF_FFFF_FFFF, 7'b1111111, 48, 1'b0);
        check_all("R2 reversed address");
    endtask

    task automatic t_count();
        send(GOOD_ADDR, 2'd1, 36'hA_AAAA_AAAA, 7'd0, 47, 1'b0);
        check_all("R3 short frame");
        send(GOOD_ADDR, 2'd1, 36'hB_BBBB_BBBB, 7'd0, 49, 1'b0);
        check_all("R3 long frame");
    endtask

    task automatic t_commit_timing();
        addr_phase(GOOD_ADDR, 1'b0);
        payload_phase(make_frame(2'd3, 36'h0_0C0F_FEE5, 7'd0), 48, 1'b0);
        tick(20);
        check_all("R4 before enable falls");
        close_frame();
        model_commit(2'd3, 36'h0_0C0F_FEE5, 7'd0);
        check_all("R4 after enable falls");
    endtask

    task automatic t_ctrl_other_bank();
        logic [47:0] p;
        p = make_frame(2'd1, 36'h7_0000_000E, 7'd0) | (48'h7F << 39) | (48'h7 << 36);
        addr_phase(GOOD_ADDR, 1'b0);
        payload_phase(p, 48, 1'b0);
        close_frame();
        model_commit(2'd1, 36'h7_0000_000E, 7'd0);
        check_all("R6 bank1 leaves control");
    endtask

    task automatic t_inhibit();
        disp_en = 1'b0;
        tick(2);
        check_all("R9 blanked");
        send(GOOD_ADDR, 2'd0, 36'hC_0FFE_E123, 7'b0110001, 48, 1'b0);
        model_commit(2'd0, 36'hC_0FFE_E123, 7'b0110001);
        check_all("R9 transfer while blanked");
        disp_en = 1'b1;
        tick(2);
        check_all("R9 unblanked");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        ce_in   = 1'b0;
        sck_in  = 1'b0;
        sdi_in  = 1'b0;
        disp_en = 1'b1;
        exp_img = '0;
        exp_mode = '0;
        exp_bias = 1'b0;
        exp_off  = 1'b0;
        exp_ps   = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_bank0();
        t_banks();
        t_idle_high();
        t_bad_addr();
        t_count();
        t_commit_timing();
        t_ctrl_other_bank();
        t_inhibit();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule